// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is a watchdog for a system controller. Software sets a 32-bit timeout and a 32-bit early-warning threshold, each split into a high half and a low half of 16 bits. Writing the low half of the threshold starts a transfer of the timeout into the down-counter. The counter then steps down once per slow tick, at 32768 ticks per second. When the count lands on the threshold, the block raises a maskable interrupt. When the count runs out, the block raises a sticky reset request and holds the count at zero. Software restarts the count the same way it first loaded it, so that load sequence also serves as the keepalive.

A key register guards every other register against stray writes. Writing 16'hE551 to it opens the block. Writing any other value closes it again.

The transfer of the timeout is paced by the slow tick and is run by a small state machine with four states:
- `LD_IDLE`: nothing is pending.
- `LD_SYNC1`: entered on a permitted write to the threshold-low register.
- `LD_SYNC2`: entered on the next tick.
- `LD_COMMIT`: entered on the tick after that.

On the third tick the machine copies the timeout into the counter and returns to `LD_IDLE`. A new trigger in any state returns the machine to `LD_SYNC1`. A status bit reports the transfer as busy in every state other than `LD_IDLE`.

Top module: `wdog_locked_timer`

## Requirements
- R1: After reset, every register reads 0 except the key register, which reads 1 (locked). `irq` and `rst_req` are 0.
- R2: Writing 16'hE551 to the key register (0x20) unlocks the block. Writing any other value locks it. While the block is locked, writes to every other offset are ignored.
- R3: The register offsets are as follows:
  - 0x00 timeout-low and 0x04 timeout-high. Each keeps bits 15:0 of the write data.
  - 0x2C threshold-low and 0x30 threshold-high. Each keeps bits 15:0 of the write data.
  - 0x08 control, 4 bits. Bit 0 enables the interrupt, bit 1 enables counting, bit 2 is a run flag that is only stored, and bit 3 enables the reset.
  - 0x14 mask, bit 0.
  - 0x0C clear register, which always reads 0.
  - Unused bits read 0.
- R4: A permitted write to threshold-low starts a transfer. On the third following tick, the counter takes the value {timeout-high, timeout-low}.
- R5: Raw status bit 4 (offset 0x10) reads 1 from the cycle after the trigger until the committing tick. It reads 0 afterwards.
- R6: When counting is enabled, the counter decrements by one on each tick except the committing tick. Offsets 0x1C and 0x18 return the live count bits 31:16 and 15:0.
- R7: When a decrement lands on {threshold-high, threshold-low} with control bit 0 set, raw bit 0 sets. `irq` equals raw bit 0 AND NOT mask bit 0.
- R8: When a decrement reaches 0 with control bit 3 set, raw bit 3 and `rst_req` set and stay set until they are cleared. The count holds at 0.
- R9: Writing to offset 0x0C with bit 0 set clears raw bit 0. Writing with bit 3 set clears raw bit 3. A set event in the same cycle wins.
- R10: With counting disabled, the count is frozen and neither event can set.
- R11: A transfer issued while the counter is running restarts the count from the timeout value (keepalive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick | input | 1 | Slow-tick strobe, one clk cycle wide |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | System reset request |

## Verification
The embedded assertions check four properties on every cycle:
- Writes made while locked leave the control register unchanged.
- The busy flag drops after a commit.
- The count freezes when counting is disabled and holds once it reaches zero.
- The reset status is sticky.

Some behaviours can only be shown by the bench's scenarios: the exact tick on which a transfer lands, the interrupt firing on the threshold crossing, masking, keepalive restarts, and the carry from the low half of the count into the high half.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 16;
    localparam int CNT_W   = 2 * FIELD_W;
    localparam int CTRL_W  = 4;
    localparam logic [FIELD_W-1:0] UNLOCK_KEY = 16'hE551;

    localparam logic [ADDR_W-1:0] OFS_TMO_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TMO_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_KEY    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_THR_LO = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_THR_HI = 6'h30;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SYNC1  = 2'd1,
        LD_SYNC2  = 2'd2,
        LD_COMMIT = 2'd3
    } ld_state_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                busy,
    input  logic                int_raw,
    input  logic                rst_raw,
    output logic [CTRL_W-1:0]   ctrl,
    output logic                mask,
    output logic [CNT_W-1:0]    tmo_val,
    output logic [CNT_W-1:0]    thr_val,
    output logic                start_load,
    output logic                clr_int,
    output logic                clr_rst
);
    logic [FIELD_W-1:0] tmo_lo, tmo_hi, thr_lo, thr_hi;
    logic               locked;
    logic               wr_ok;
    logic [DATA_W-FIELD_W-1:0] unused_wdata;

    assign unused_wdata = wdata[DATA_W-1:FIELD_W];
    assign wr_ok        = wr && !locked && (addr != OFS_KEY);
    assign start_load   = wr_ok && (addr == OFS_THR_LO);
    assign clr_int      = wr_ok && (addr == OFS_CLEAR) && wdata[0];
    assign clr_rst      = wr_ok && (addr == OFS_CLEAR) && wdata[3];
    assign tmo_val      = {tmo_hi, tmo_lo};
    assign thr_val      = {thr_hi, thr_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b1;
            tmo_lo <= '0;
            tmo_hi <= '0;
            thr_lo <= '0;
            thr_hi <= '0;
            ctrl   <= '0;
            mask   <= 1'b0;
        end else if (wr && addr == OFS_KEY) begin
            locked <= (wdata[FIELD_W-1:0] != UNLOCK_KEY);
        end else if (wr_ok) begin
            unique case (addr)
                OFS_TMO_LO: tmo_lo <= wdata[FIELD_W-1:0];
                OFS_TMO_HI: tmo_hi <= wdata[FIELD_W-1:0];
                OFS_THR_LO: thr_lo <= wdata[FIELD_W-1:0];
                OFS_THR_HI: thr_hi <= wdata[FIELD_W-1:0];
                OFS_CTRL:   ctrl   <= wdata[CTRL_W-1:0];
                OFS_MASK:   mask   <= wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_TMO_LO: rdata[FIELD_W-1:0] = tmo_lo;
            OFS_TMO_HI: rdata[FIELD_W-1:0] = tmo_hi;
            OFS_THR_LO: rdata[FIELD_W-1:0] = thr_lo;
            OFS_THR_HI: rdata[FIELD_W-1:0] = thr_hi;
            OFS_CTRL:   rdata[CTRL_W-1:0]  = ctrl;
            OFS_MASK:   rdata[0]           = mask;
            OFS_RAW:    rdata[4:0]         = {busy, rst_raw, 2'b00, int_raw};
            OFS_CNT_LO: rdata[FIELD_W-1:0] = cnt[FIELD_W-1:0];
            OFS_CNT_HI: rdata[FIELD_W-1:0] = cnt[CNT_W-1:FIELD_W];
            OFS_KEY:    rdata[0]           = locked;
            default:    rdata = '0;
        endcase
    end

    // R2: a locked control register cannot be changed by a bus write
    p_locked_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr && addr == OFS_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/wdog_load_fsm.sv
module wdog_load_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_load,
    output logic busy,
    output logic commit
);
    ld_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE:   state_nx = LD_IDLE;
            LD_SYNC1:  if (tick) state_nx = LD_SYNC2;
            LD_SYNC2:  if (tick) state_nx = LD_COMMIT;
            LD_COMMIT: if (tick) state_nx = LD_IDLE;
            default:   state_nx = LD_IDLE;
        endcase
        if (start_load) state_nx = LD_SYNC1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        busy   = (state != LD_IDLE);
        commit = (state == LD_COMMIT) && tick && !start_load;
    end

    // R5: after a commit with no new trigger, busy reads 0
    p_busy_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             commit,
    input  logic [CNT_W-1:0] tmo_val,
    input  logic [CNT_W-1:0] thr_val,
    input  logic             cnt_en,
    input  logic             int_en,
    input  logic             rst_en,
    input  logic             clr_int,
    input  logic             clr_rst,
    output logic [CNT_W-1:0] cnt,
    output logic             int_raw,
    output logic             rst_raw
);
    logic             step;
    logic [CNT_W-1:0] cnt_dec;

    assign step    = tick && cnt_en && (cnt != '0) && !commit;
    assign cnt_dec = cnt - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            int_raw <= 1'b0;
            rst_raw <= 1'b0;
        end else begin
            if (commit)    cnt <= tmo_val;
            else if (step) cnt <= cnt_dec;

            if (step && int_en && cnt_dec == thr_val) int_raw <= 1'b1;
            else if (clr_int)                         int_raw <= 1'b0;

            if (step && rst_en && cnt_dec == '0) rst_raw <= 1'b1;
            else if (clr_rst)                    rst_raw <= 1'b0;
        end
    end

    // R8: the count holds at zero until a new transfer
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !commit) |=> (cnt == '0));
    // R8: reset status is sticky until cleared
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_raw && !clr_rst) |=> rst_raw);
    // R10: disabled counting freezes the count
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !commit) |=> $stable(cnt));
endmodule

// File: rtl/wdog_locked_timer.sv
module wdog_locked_timer
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              irq,
    output logic              rst_req
);
    logic [CNT_W-1:0]  cnt, tmo_val, thr_val;
    logic [CTRL_W-1:0] ctrl;
    logic mask, busy, commit, start_load, clr_int, clr_rst, int_raw, rst_raw;

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .busy(busy),
        .int_raw(int_raw), .rst_raw(rst_raw), .ctrl(ctrl), .mask(mask),
        .tmo_val(tmo_val), .thr_val(thr_val), .start_load(start_load),
        .clr_int(clr_int), .clr_rst(clr_rst)
    );

    wdog_load_fsm u_load (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_load(start_load),
        .busy(busy), .commit(commit)
    );

    wdog_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit),
        .tmo_val(tmo_val), .thr_val(thr_val), .cnt_en(ctrl[1]),
        .int_en(ctrl[0]), .rst_en(ctrl[3]), .clr_int(clr_int),
        .clr_rst(clr_rst), .cnt(cnt), .int_raw(int_raw), .rst_raw(rst_raw)
    );

    assign irq     = int_raw && !mask;
    assign rst_req = rst_raw;

    // R7: a masked interrupt never reaches the pin
    p_mask_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq);
endmodule

// File: tb/tb_wdog_locked_timer.sv
module tb_wdog_locked_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        irq, rst_req;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_locked_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .irq(irq), .rst_req(rst_req)
    );

    // write/readback vectors: offset, write data, expected read (R3)
    localparam int NV = 6;
    localparam logic [5:0]  V_ADDR [NV] = '{6'h00, 6'h04, 6'h08, 6'h14, 6'h30, 6'h0C};
    localparam logic [31:0] V_WR   [NV] = '{32'hABCD1234, 32'h00015678, 32'hFFFFFFF5,
                                            32'h0000FFFF, 32'h0001BEEF, 32'hFFFFFFFF};
    localparam logic [31:0] V_EXP  [NV] = '{32'h1234, 32'h5678, 32'h5, 32'h1, 32'hBEEF, 32'h0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic cnt_is(input string req, input logic [31:0] exp);
        logic [31:0] lo, hi;
        rd(6'h18, lo);
        rd(6'h1C, hi);
        chk(req, {hi[15:0], lo[15:0]}, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(6'h20, d); chk("R1 key", d, 32'h1);
        rd(6'h08, d); chk("R1 ctrl", d, 32'h0);
        rd(6'h10, d); chk("R1 raw", d, 32'h0);
        chk("R1 pins", {30'd0, irq, rst_req}, 32'h0);
        // R2 locked write ignored
        wr(6'h08, 32'hF);
        rd(6'h08, d); chk("R2 locked ctrl", d, 32'h0);
        wr(6'h20, 32'hE551);
        rd(6'h20, d); chk("R2 unlocked", d, 32'h0);
        // R3 table walk
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WR[i]);
            rd(V_ADDR[i], d);
            chk("R3 readback", d, V_EXP[i]);
        end
        // R4/R5 transfer
        wr(6'h08, 32'h0);
        wr(6'h14, 32'h0);
        wr(6'h00, 32'd10); wr(6'h04, 32'h0); wr(6'h30, 32'h0);
        wr(6'h2C, 32'd4);
        rd(6'h10, d); chk("R5 busy set", d, 32'h10);
        ticks(2);
        rd(6'h10, d); chk("R5 busy after 2 ticks", d, 32'h10);
        cnt_is("R4 not yet loaded", 32'h0);
        ticks(1);
        rd(6'h10, d); chk("R5 busy clear", d, 32'h0);
        cnt_is("R4 loaded", 32'd10);
        // R6/R7 count and threshold
        wr(6'h08, 32'hF);
        ticks(5);
        cnt_is("R6 count", 32'd5);
        chk("R7 no irq yet", {31'd0, irq}, 32'h0);
        ticks(1);
        chk("R7 irq", {31'd0, irq}, 32'h1);
        wr(6'h14, 32'h1);
        chk("R7 masked", {31'd0, irq}, 32'h0);
        rd(6'h10, d); chk("R7 raw under mask", d, 32'h1);
        wr(6'h14, 32'h0);
        wr(6'h0C, 32'h1);
        rd(6'h10, d); chk("R9 int cleared", d, 32'h0);
        // R11 keepalive
        wr(6'h2C, 32'd4);
        ticks(3);
        cnt_is("R11 restart", 32'd10);
        // R10 freeze
        wr(6'h08, 32'hD);
        ticks(3);
        cnt_is("R10 frozen", 32'd10);
        rd(6'h10, d); chk("R10 no events", d, 32'h0);
        // R8 expiry
        wr(6'h08, 32'hF);
        ticks(10);
        cnt_is("R8 zero", 32'h0);
        chk("R8 rst_req", {31'd0, rst_req}, 32'h1);
        rd(6'h10, d); chk("R8 raw both", d, 32'h9);
        ticks(2);
        cnt_is("R8 hold zero", 32'h0);
        // R2 locked clear ignored
        wr(6'h20, 32'h0);
        wr(6'h0C, 32'h8);
        chk("R2 locked clear ignored", {31'd0, rst_req}, 32'h1);
        wr(6'h20, 32'hE551);
        wr(6'h0C, 32'h8);
        chk("R9 rst cleared", {31'd0, rst_req}, 32'h0);
        rd(6'h10, d); chk("R9 raw", d, 32'h1);
        // R6 carry across halves
        wr(6'h08, 32'h0);
        wr(6'h00, 32'h0); wr(6'h04, 32'h1);
        wr(6'h2C, 32'h5);
        ticks(3);
        cnt_is("R6 split load", 32'h10000);
        wr(6'h08, 32'h2);
        ticks(1);
        cnt_is("R6 borrow", 32'h0FFFF);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule